// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Unit

This unit holds the processor's status flags and makes the control-flow decision for two-word conditional jumps and calls. When a compare instruction is presented, it weighs the accumulator against a fetched operand word. It then rewrites the three relation flags and the accumulator-sign flag.

When a conditional branch is presented, it picks one flag by a 3-bit index carried in the instruction and tests it for set or clear. One cycle later it reports the branch decision and the next PC. For a taken call it also raises a one-cycle push request that carries the return address.

The carry flag and the shift flag sit in the same register. Neighbouring arithmetic and shift logic writes them through separate write-enable inputs, and compare never touches them. Stack storage and operand fetch are done elsewhere. The unit receives the operand word and the address of the instruction word already resolved.

Top module: `flagbr_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `flags` is all zeros and `decideValid`, `branchTaken` and `pushValid` are low.
- R2: A valid instruction with code 9'o200 (compare) rewrites the relation flags in the following cycle. Bit 0 is set when the operand equals `accIn`. Bit 1 is set when the operand is greater than `accIn`. Bit 2 is set when the operand is less than `accIn`. The comparison is unsigned, and exactly one of these three bits is set.
- R3: A compare sets flag bit 4 to the most significant bit of `accIn` (value 9'o400) and leaves flag bit 3 (carry) and flag bit 5 (shift) unchanged.
- R4: `carryWe`/`carryIn` write flag bit 3 and `shiftWe`/`shiftIn` write flag bit 5 in any cycle. This includes a cycle that also carries a compare, and in that case both updates take effect together.
- R5: A branch instruction has bits [8:5] = 4'b0110. Bits [4:3] select the variant: 00 jump-if-set, 01 jump-if-clear, 10 call-if-set, 11 call-if-clear. Bits [2:0] give the flag index. Its decision appears with `decideValid` high for exactly the cycle after the instruction.
- R6: A set variant is taken when the indexed flag is 1, and a clear variant is taken when it is 0.
- R7: A taken branch gives `pcNext` = `operand`. A branch that is not taken gives `pcNext` = `pcIn` + 2, modulo 512.
- R8: A taken call raises `pushValid` for one cycle with `pushData` = `pcIn` + 2, modulo 512. Jumps and calls that are not taken never raise `pushValid`.
- R9: Flag indices 6 and 7 read as 0, so a set variant using them is never taken and a clear variant using them is always taken.
- R10: A branch tests the flag value held before any flag write made in the same cycle as the branch.
- R11: Any other instruction code changes no flag and raises neither `decideValid` nor `pushValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction code and operands present this cycle |
| instrCode | input | 9 | Instruction code |
| accIn | input | 9 | Accumulator value |
| operand | input | 9 | Operand word (compare value or branch target) |
| pcIn | input | 9 | Address of the instruction word |
| carryWe | input | 1 | Write enable for the carry flag |
| carryIn | input | 1 | New carry flag value |
| shiftWe | input | 1 | Write enable for the shift flag |
| shiftIn | input | 1 | New shift flag value |
| flags | output | 6 | Flag register |
| decideValid | output | 1 | Branch decision present |
| branchTaken | output | 1 | Branch or call taken |
| pcNext | output | 9 | Next PC for the decided branch |
| pushValid | output | 1 | Push return address |
| pushData | output | 9 | Return address to push |

## Verification
Two flag writers can act in the same cycle. The first case is a compare arriving together with a carry or shift write. The bench sends a compare while it sets the shift flag, and another compare while it clears the carry flag. It then checks that both the relation bits and the side-written bit land correctly.

The second case is a branch that tests the carry flag in the very cycle that the carry flag is written. The bench expects the decision to follow the old flag value, while the register takes the new one.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;
  localparam int CODE_W = 9;
  localparam int FLAG_W = 6;
  localparam int IDX_W  = 3;

  localparam int F_EQ    = 0;
  localparam int F_GT    = 1;
  localparam int F_LT    = 2;
  localparam int F_CARRY = 3;
  localparam int F_MSB   = 4;
  localparam int F_SHIFT = 5;

  localparam logic [CODE_W-1:0] OP_COMPARE = 9'o200;
  localparam logic [3:0]        BR_PREFIX  = 4'b0110;

  typedef enum logic [1:0] {
    BR_JMP_SET  = 2'b00,
    BR_JMP_CLR  = 2'b01,
    BR_CALL_SET = 2'b10,
    BR_CALL_CLR = 2'b11
  } brKind_t;

  typedef struct packed {
    logic             cmpEn;
    logic             brEn;
    logic             wantClear;
    logic             isCall;
    logic [IDX_W-1:0] flagIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/flagbr_ctrl.sv
module flagbr_ctrl
  import flagbr_pkg::*;
(
  input  logic              instrValid,
  input  logic [CODE_W-1:0] instrCode,
  output ctlStrobes_t       ctl
);
  brKind_t kind;

  assign kind = brKind_t'(instrCode[4:3]);

  always_comb begin
    ctl = '0;
    if (instrValid) begin
      if (instrCode == OP_COMPARE) begin
        ctl.cmpEn = 1'b1;
      end else if (instrCode[CODE_W-1:5] == BR_PREFIX) begin
        ctl.brEn    = 1'b1;
        ctl.flagIdx = instrCode[IDX_W-1:0];
        unique case (kind)
          BR_JMP_SET:  begin ctl.wantClear = 1'b0; ctl.isCall = 1'b0; end
          BR_JMP_CLR:  begin ctl.wantClear = 1'b1; ctl.isCall = 1'b0; end
          BR_CALL_SET: begin ctl.wantClear = 1'b0; ctl.isCall = 1'b1; end
          BR_CALL_CLR: begin ctl.wantClear = 1'b1; ctl.isCall = 1'b1; end
          default:     begin ctl.wantClear = 1'b0; ctl.isCall = 1'b0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/flagbr_dpath.sv
module flagbr_dpath
  import flagbr_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] pcIn,
  input  logic              carryWe,
  input  logic              carryIn,
  input  logic              shiftWe,
  input  logic              shiftIn,
  output logic [FLAG_W-1:0] flags,
  output logic              decideValid,
  output logic              branchTaken,
  output logic [DATA_W-1:0] pcNext,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData
);
  localparam int IDX_SPAN = 1 << IDX_W;
  localparam int SKIP_WORDS = 2;

  logic [FLAG_W-1:0]   flagsQ, flagsD;
  logic [IDX_SPAN-1:0] flagsWide;
  logic                selBit, takeIt;
  logic [DATA_W-1:0]   retAddr;

  // Indices past the implemented flags see zero.
  assign flagsWide = IDX_SPAN'(flagsQ);
  assign selBit    = flagsWide[ctl.flagIdx];
  assign takeIt    = ctl.brEn & (selBit ^ ctl.wantClear);
  assign retAddr   = pcIn + DATA_W'(SKIP_WORDS);

  always_comb begin
    flagsD = flagsQ;
    if (ctl.cmpEn) begin
      flagsD[F_EQ]  = (operand == accIn);
      flagsD[F_GT]  = (operand >  accIn);
      flagsD[F_LT]  = (operand <  accIn);
      flagsD[F_MSB] = accIn[DATA_W-1];
    end
    if (carryWe) flagsD[F_CARRY] = carryIn;
    if (shiftWe) flagsD[F_SHIFT] = shiftIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ      <= '0;
      decideValid <= 1'b0;
      branchTaken <= 1'b0;
      pcNext      <= '0;
      pushValid   <= 1'b0;
      pushData    <= '0;
    end else begin
      flagsQ      <= flagsD;
      decideValid <= ctl.brEn;
      branchTaken <= takeIt;
      pushValid   <= takeIt & ctl.isCall;
      if (ctl.brEn) pcNext <= takeIt ? operand : retAddr;
      if (takeIt & ctl.isCall) pushData <= retAddr;
    end
  end

  assign flags = flagsQ;
endmodule

// File: rtl/flagbr_unit.sv
module flagbr_unit
  import flagbr_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [CODE_W-1:0] instrCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] pcIn,
  input  logic              carryWe,
  input  logic              carryIn,
  input  logic              shiftWe,
  input  logic              shiftIn,
  output logic [FLAG_W-1:0] flags,
  output logic              decideValid,
  output logic              branchTaken,
  output logic [DATA_W-1:0] pcNext,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData
);
  ctlStrobes_t ctl;

  flagbr_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrCode  (instrCode),
    .ctl        (ctl)
  );

  flagbr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .accIn       (accIn),
    .operand     (operand),
    .pcIn        (pcIn),
    .carryWe     (carryWe),
    .carryIn     (carryIn),
    .shiftWe     (shiftWe),
    .shiftIn     (shiftIn),
    .flags       (flags),
    .decideValid (decideValid),
    .branchTaken (branchTaken),
    .pcNext      (pcNext),
    .pushValid   (pushValid),
    .pushData    (pushData)
  );
endmodule

// File: rtl/flagbr_unit_chk.sv
module flagbr_unit_chk
  import flagbr_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] pcIn,
  input logic              carryWe,
  input logic [FLAG_W-1:0] flags,
  input logic              decideValid,
  input logic              branchTaken,
  input logic [DATA_W-1:0] pcNext,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushData
);
  AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags[F_LT:F_EQ])); // R2

  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(carryWe) |-> flags[F_CARRY] == $past(flags[F_CARRY])); // R3

  AST_DECIDE_NEEDS_INSTR: assert property (@(posedge clk) disable iff (!rstN)
    !$past(instrValid) |-> !decideValid); // R5

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && branchTaken) |-> pcNext == $past(operand)); // R7

  AST_SKIP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (decideValid && !branchTaken) |-> pcNext == DATA_W'($past(pcIn) + DATA_W'(2))); // R7

  AST_PUSH_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (decideValid && branchTaken)); // R8

  AST_PUSH_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> pushData == DATA_W'($past(pcIn) + DATA_W'(2))); // R8
endmodule

bind flagbr_unit flagbr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .instrValid  (instrValid),
  .operand     (operand),
  .pcIn        (pcIn),
  .carryWe     (carryWe),
  .flags       (flags),
  .decideValid (decideValid),
  .branchTaken (branchTaken),
  .pcNext      (pcNext),
  .pushValid   (pushValid),
  .pushData    (pushData)
);

// File: tb/flagbr_unit_bench.sv
module flagbr_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrValid = 1'b0;
  logic [8:0] instrCode = '0;
  logic [8:0] accIn = '0;
  logic [8:0] operand = '0;
  logic [8:0] pcIn = '0;
  logic       carryWe = 1'b0, carryIn = 1'b0, shiftWe = 1'b0, shiftIn = 1'b0;
  logic [5:0] flags;
  logic       decideValid, branchTaken, pushValid;
  logic [8:0] pcNext, pushData;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  flagbr_unit u_flagbr_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrCode(instrCode),
    .accIn(accIn), .operand(operand), .pcIn(pcIn),
    .carryWe(carryWe), .carryIn(carryIn), .shiftWe(shiftWe), .shiftIn(shiftIn),
    .flags(flags), .decideValid(decideValid), .branchTaken(branchTaken),
    .pcNext(pcNext), .pushValid(pushValid), .pushData(pushData)
  );

  // {acc, operand, expected flags} with carry and shift at zero
  localparam logic [23:0] CMP_VEC [8] = '{
    {9'o005, 9'o005, 6'h01},
    {9'o005, 9'o011, 6'h02},
    {9'o011, 9'o005, 6'h04},
    {9'o400, 9'o400, 6'h11},
    {9'o777, 9'o000, 6'h14},
    {9'o000, 9'o777, 6'h02},
    {9'o377, 9'o400, 6'h02},
    {9'o401, 9'o377, 6'h14}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one cycle of inputs, then sample after the capturing edge.
  task automatic step(input logic iv, input logic [8:0] code, input logic [8:0] acc,
                      input logic [8:0] opw, input logic [8:0] pc,
                      input logic cWe, input logic cIn, input logic sWe, input logic sIn);
    @(negedge clk);
    instrValid = iv; instrCode = code; accIn = acc; operand = opw; pcIn = pc;
    carryWe = cWe; carryIn = cIn; shiftWe = sWe; shiftIn = sIn;
    @(negedge clk);
    instrValid = 1'b0; carryWe = 1'b0; shiftWe = 1'b0;
  endtask

  task automatic checkBranch(string tag, logic expTaken, logic [8:0] expPc,
                             logic expPush, logic [8:0] expData);
    check({tag, " decide"}, 32'(decideValid), 32'd1);
    check({tag, " taken"}, 32'(branchTaken), 32'(expTaken));
    check({tag, " pcNext"}, 32'(pcNext), 32'(expPc));
    check({tag, " push"}, 32'(pushValid), 32'(expPush));
    if (expPush) check({tag, " pushData"}, 32'(pushData), 32'(expData));
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 32'(flags), 32'h0);
    check("R1 decide in reset", 32'(decideValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", 32'(flags), 32'h0);
    check("R1 push after reset", 32'(pushValid), 32'd0);

    // R2 / R3: compare table
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 9'o200, CMP_VEC[i][23:15], CMP_VEC[i][14:6], 9'o010, 0, 0, 0, 0);
      check($sformatf("R2 R3 compare vec %0d", i), 32'(flags), 32'(CMP_VEC[i][5:0]));
      check("R5 compare gives no decision", 32'(decideValid), 32'd0);
    end

    // R4: carry write alone
    step(1'b0, 9'o000, 0, 0, 0, 1, 1, 0, 0);
    check("R4 carry write", 32'(flags), 32'h1C);
    // R3 R4: compare plus shift write, carry preserved
    step(1'b1, 9'o200, 9'o007, 9'o007, 0, 0, 0, 1, 1);
    check("R3 R4 compare with shift write", 32'(flags), 32'h29);
    // R4: compare plus carry clear
    step(1'b1, 9'o200, 9'o007, 9'o010, 0, 1, 0, 0, 0);
    check("R4 compare with carry clear", 32'(flags), 32'h22);

    // flags now: gt, shift
    step(1'b1, 9'o301, 0, 9'o250, 9'o100, 0, 0, 0, 0);
    checkBranch("R6 R7 jmp-set gt", 1, 9'o250, 0, 0);
    step(1'b1, 9'o300, 0, 9'o250, 9'o100, 0, 0, 0, 0);
    checkBranch("R6 R7 jmp-set eq", 0, 9'o102, 0, 0);
    step(1'b1, 9'o310, 0, 9'o250, 9'o100, 0, 0, 0, 0);
    checkBranch("R6 jmp-clr eq", 1, 9'o250, 0, 0);
    step(1'b1, 9'o325, 0, 9'o040, 9'o776, 0, 0, 0, 0);
    checkBranch("R8 call-set shift wrap", 1, 9'o040, 1, 9'o000);
    step(1'b1, 9'o335, 0, 9'o040, 9'o776, 0, 0, 0, 0);
    checkBranch("R8 call-clr shift", 0, 9'o000, 0, 0);
    step(1'b1, 9'o333, 0, 9'o321, 9'o123, 0, 0, 0, 0);
    checkBranch("R8 call-clr carry", 1, 9'o321, 1, 9'o125);
    step(1'b1, 9'o306, 0, 9'o055, 9'o200, 0, 0, 0, 0);
    checkBranch("R9 index 6 set", 0, 9'o202, 0, 0);
    step(1'b1, 9'o317, 0, 9'o055, 9'o200, 0, 0, 0, 0);
    checkBranch("R9 index 7 clear", 1, 9'o055, 0, 0);

    // R10: branch on carry while carry written
    step(1'b1, 9'o313, 0, 9'o444, 9'o010, 1, 1, 0, 0);
    checkBranch("R10 old carry used", 1, 9'o444, 0, 0);
    check("R10 carry written", 32'(flags), 32'h2A);
    @(negedge clk);
    check("R5 decision is one cycle", 32'(decideValid), 32'd0);

    // R11: other code
    step(1'b1, 9'o401, 9'o000, 9'o000, 9'o010, 0, 0, 0, 0);
    check("R11 flags unchanged", 32'(flags), 32'h2A);
    check("R11 no decision", 32'(decideValid), 32'd0);
    check("R11 no push", 32'(pushValid), 32'd0);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 flags cleared by reset", 32'(flags), 32'h0);
    rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule